// File: doc/BRIEF.md
# Shift and Rotate Flag Unit

This block computes one shift or rotate on an 8-bit or 16-bit operand and derives the new arithmetic flags for it. A request carries an operation code, a width select, the operand, a shift count and the current flag set. The block returns the shifted result together with a fresh Carry, Overflow, AuxCarry, Parity, Sign and Zero. Each operation class updates the flags by fixed rules. A masked count of zero keeps the old Carry. Left and right operations take Overflow from different bits. One otherwise idle operation code clears the result instead of shifting.

Requests enter on a valid/ready pair, and results leave on a second one. One request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears registered on the next cycle. `in_ready` is high whenever the output register is empty or is being drained on the same edge. When `out_valid` is high and `out_ready` is low, the output stage stalls: the result and flags stay frozen and no new request is taken. The shift itself is combinational, as a chain of single-bit steps, between the two handshakes.

Top module: `shiftrot_unit`

## Requirements
- R1: With `in_wide` low the unit works on bits 7:0 only. Operand bits 15:8 are ignored, result bits 15:8 are zero, and the top bit for Sign and Overflow is bit 7. With `in_wide` high all 16 bits are used and the top bit is bit 15.
- R2: Only the low 5 bits of `in_count` are used, so a count of 33 behaves exactly like a count of 1.
- R3: When the masked count is zero, the result equals the operand and Carry (flag bit 0) keeps its incoming value.
- R4: For a nonzero masked count, Carry is the last bit moved out of the operand. For rotates through carry, it is the bit that ends up in the carry slot of the ring.
- R5: Operation codes 0 (rotate left) and 1 (rotate right) rotate within the operand width. Codes 2 (rotate left through carry) and 3 (rotate right through carry) rotate a ring of width+1 bits, with Carry as the extra bit. Counts may exceed the ring length.
- R6: Rotates (codes 0 to 3) pass Parity (bit 1), AuxCarry (bit 2), Zero (bit 3) and Sign (bit 4) of `in_flags` through unchanged.
- R7: Shifts (codes 4 logical left, 5 logical right, 7 arithmetic right, and code 6) clear AuxCarry. They set Parity to 1 when bits 7:0 of the result hold an even number of ones, set Sign from the top result bit, and set Zero when the result is zero.
- R8: For left-direction codes (0, 2, 4, 6), Overflow (bit 5) is the new Carry XOR the top result bit.
- R9: For right-direction codes (1, 3, 5, 7), Overflow is the XOR of the top two result bits.
- R10: Code 6 forces the result to zero. Its flags follow the logical-left rules on a zero operand: Carry is 0 for a nonzero count and kept for a zero count, Overflow equals Carry, Parity is 1, Zero is 1, Sign is 0 and AuxCarry is 0.
- R11: Arithmetic shift right (code 7) copies the original sign bit into every vacated position. Counts at or above the width give all sign bits, with Carry equal to the sign.
- R12: A request is taken when `in_valid` and `in_ready` are high, and its result is valid on the next cycle. While `out_valid` is high and `out_ready` is low, `in_ready` is low and the result and flags hold steady. After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 3 | Operation code 0 to 7 |
| in_wide | input | 1 | 1 selects 16-bit, 0 selects 8-bit |
| in_operand | input | 16 | Value to shift or rotate |
| in_count | input | 8 | Shift count; only the low 5 bits are used |
| in_flags | input | 6 | Incoming flags {O,S,Z,A,P,C} from bit 5 down to bit 0 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 16 | Shifted or rotated value |
| out_flags | output | 6 | Updated flags, same bit order as `in_flags` |

## Verification
A wrong step in the shift chain shows up one cycle after acceptance. It appears as a bad result bit, or as a wrong Carry from the last step, mostly at counts near the width or ring length. Errors in flag selection appear in the same cycle: a rotate that disturbs Parity, Sign, Zero or AuxCarry, or Overflow taken from the wrong bit pair. A fault in the output register shows only under back-pressure, as a result that changes or is lost while `out_ready` is low. So every count from 0 to 31 is swept across all codes and both widths, and the stall is exercised on its own.

// File: rtl/shiftrot_pkg.sv
package shiftrot_pkg;
  localparam int DATA_W    = 16;
  localparam int NARROW_W  = 8;
  localparam int CNT_W     = 8;
  localparam int MASK_BITS = 5;
  localparam int STEPS     = (1 << MASK_BITS) - 1;

  localparam int FLG_C = 0;
  localparam int FLG_P = 1;
  localparam int FLG_A = 2;
  localparam int FLG_Z = 3;
  localparam int FLG_S = 4;
  localparam int FLG_O = 5;
  localparam int FLG_W = 6;

  typedef enum logic [2:0] {
    OP_ROTL = 3'd0,
    OP_ROTR = 3'd1,
    OP_RCL  = 3'd2,
    OP_RCR  = 3'd3,
    OP_SHL  = 3'd4,
    OP_SHR  = 3'd5,
    OP_ZERO = 3'd6,
    OP_SAR  = 3'd7
  } sr_op_e;

  typedef struct packed {
    logic              c;
    logic [DATA_W-1:0] v;
  } sr_state_t;

  function automatic logic [DATA_W-1:0] width_mask(input logic wide);
    return wide ? {DATA_W{1'b1}} : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  endfunction

  function automatic logic [DATA_W-1:0] top_bit(input logic wide);
    return wide ? (DATA_W'(1) << (DATA_W-1)) : (DATA_W'(1) << (NARROW_W-1));
  endfunction

  function automatic logic is_left(input sr_op_e op);
    return (op == OP_ROTL) || (op == OP_RCL) || (op == OP_SHL) || (op == OP_ZERO);
  endfunction

  function automatic logic is_rotate(input sr_op_e op);
    return (op == OP_ROTL) || (op == OP_ROTR) || (op == OP_RCL) || (op == OP_RCR);
  endfunction
endpackage

// File: rtl/shiftrot_step.sv
module shiftrot_step
  import shiftrot_pkg::*;
(
  input  sr_op_e    op,
  input  logic      wide,
  input  logic      active,
  input  sr_state_t cur,
  output sr_state_t nxt
);
  logic [DATA_W-1:0] tmask;
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] shifted;
  logic              msb;
  logic              lsb;
  logic              cout;

  always_comb begin
    tmask = top_bit(wide);
    wmask = width_mask(wide);
    msb   = |(cur.v & tmask);
    lsb   = cur.v[0];
    unique case (op)
      OP_ROTL: begin shifted = (cur.v << 1) | DATA_W'(msb);  cout = msb; end
      OP_ROTR: begin shifted = (cur.v >> 1) | (lsb ? tmask : '0); cout = lsb; end
      OP_RCL:  begin shifted = (cur.v << 1) | DATA_W'(cur.c); cout = msb; end
      OP_RCR:  begin shifted = (cur.v >> 1) | (cur.c ? tmask : '0); cout = lsb; end
      OP_SHR:  begin shifted = cur.v >> 1; cout = lsb; end
      OP_SAR:  begin shifted = (cur.v >> 1) | (msb ? tmask : '0); cout = lsb; end
      default: begin shifted = cur.v << 1; cout = msb; end
    endcase
    if (active) begin
      nxt.v = shifted & wmask;
      nxt.c = cout;
    end else begin
      nxt = cur;
    end
  end
endmodule

// File: rtl/shiftrot_chain.sv
module shiftrot_chain
  import shiftrot_pkg::*;
(
  input  sr_op_e             op,
  input  logic               wide,
  input  logic [MASK_BITS-1:0] cnt,
  input  logic [DATA_W-1:0]  operand,
  input  logic               cin,
  output logic [DATA_W-1:0]  result,
  output logic               cout
);
  sr_state_t stage [0:STEPS];

  assign stage[0].v = operand & width_mask(wide);
  assign stage[0].c = cin;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    logic act;
    assign act = (MASK_BITS'(g) < cnt);
    shiftrot_step u_step (
      .op     (op),
      .wide   (wide),
      .active (act),
      .cur    (stage[g]),
      .nxt    (stage[g+1])
    );
  end

  assign result = stage[STEPS].v;
  assign cout   = stage[STEPS].c;
endmodule

// File: rtl/shiftrot_flags.sv
module shiftrot_flags
  import shiftrot_pkg::*;
(
  input  sr_op_e            op,
  input  logic              wide,
  input  logic [DATA_W-1:0] result,
  input  logic              carry,
  input  logic [FLG_W-1:0]  fin,
  output logic [FLG_W-1:0]  fout
);
  logic top1;
  logic top0;

  always_comb begin
    top1 = wide ? result[DATA_W-1] : result[NARROW_W-1];
    top0 = wide ? result[DATA_W-2] : result[NARROW_W-2];
    fout        = fin;
    fout[FLG_C] = carry;
    fout[FLG_O] = is_left(op) ? (carry ^ top1) : (top1 ^ top0);
    if (!is_rotate(op)) begin
      fout[FLG_A] = 1'b0;
      fout[FLG_P] = ~^result[NARROW_W-1:0];
      fout[FLG_S] = top1;
      fout[FLG_Z] = (result == '0);
    end
  end
endmodule

// File: rtl/shiftrot_unit.sv
module shiftrot_unit
  import shiftrot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic              in_wide,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [FLG_W-1:0]  in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [FLG_W-1:0]  out_flags
);
  sr_op_e               op;
  logic [MASK_BITS-1:0] cnt_m;
  logic                 cnt_unused;
  logic [DATA_W-1:0]    src;
  logic [DATA_W-1:0]    res_d;
  logic                 carry_d;
  logic [FLG_W-1:0]     flags_d;
  logic                 take;

  assign op         = sr_op_e'(in_op);
  assign cnt_m      = in_count[MASK_BITS-1:0];
  assign cnt_unused = ^in_count[CNT_W-1:MASK_BITS];
  assign src        = (op == OP_ZERO) ? '0 : in_operand;

  shiftrot_chain u_chain (
    .op      (op),
    .wide    (in_wide),
    .cnt     (cnt_m),
    .operand (src),
    .cin     (in_flags[FLG_C]),
    .result  (res_d),
    .cout    (carry_d)
  );

  shiftrot_flags u_flags (
    .op     (op),
    .wide   (in_wide),
    .result (res_d),
    .carry  (carry_d),
    .fin    (in_flags),
    .fout   (flags_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= res_d;
      out_flags  <= flags_d;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/shiftrot_chk.sv
module shiftrot_chk
  import shiftrot_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic              in_wide,
  input logic [CNT_W-1:0]  in_count,
  input logic [FLG_W-1:0]  in_flags,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic [FLG_W-1:0]  out_flags
);
  logic fire;
  logic cnt_zero;
  assign fire     = in_valid && in_ready;
  assign cnt_zero = ((in_count << (CNT_W-MASK_BITS)) == '0);

  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags));

  assert_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_keep_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cnt_zero |=> out_flags[FLG_C] == $past(in_flags[FLG_C]));

  assert_rotate_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_op[2] |=> out_flags[FLG_S:FLG_P] == $past(in_flags[FLG_S:FLG_P]));

  assert_shift_aux_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op[2] |=> !out_flags[FLG_A]);

  assert_zero_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'd6 |=> out_result == '0 && out_flags[FLG_Z]);

  assert_narrow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_wide |=> out_result[DATA_W-1:NARROW_W] == '0);
endmodule

bind shiftrot_unit shiftrot_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_wide    (in_wide),
  .in_count   (in_count),
  .in_flags   (in_flags),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_flags  (out_flags)
);

// File: tb/test_shiftrot_unit.sv
module test_shiftrot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic        in_wide = 1'b0;
  logic [15:0] in_operand = '0;
  logic [7:0]  in_count = '0;
  logic [5:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic [5:0]  out_flags;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  shiftrot_unit i_shiftrot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wide(in_wide), .in_operand(in_operand),
    .in_count(in_count), .in_flags(in_flags), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Independent reference built from the requirement text.
  function automatic logic [21:0] model(input int op, input bit wide, input int val,
                                        input int cnt, input logic [5:0] fin);
    int W, n, k, L, c, t1, t0;
    longint m, v, r, ring, full;
    longint signed sv;
    logic [5:0] f;
    W = wide ? 16 : 8;
    m = (64'(1) << W) - 1;
    v = val & m;
    n = cnt & 31;
    L = W + 1;
    r = 0; c = fin[0];
    case (op)
      0: begin k = n % W; r = ((v << k) | (v >> (W - k))) & m; c = n ? int'(r & 1) : fin[0]; end
      1: begin k = n % W; r = ((v >> k) | (v << (W - k))) & m; c = n ? int'((r >> (W-1)) & 1) : fin[0]; end
      2: begin ring = v | (longint'(fin[0]) << W); k = n % L;
               ring = ((ring << k) | (ring >> (L - k))) & ((64'(1) << L) - 1);
               r = ring & m; c = int'((ring >> W) & 1); end
      3: begin ring = v | (longint'(fin[0]) << W); k = n % L;
               ring = ((ring >> k) | (ring << (L - k))) & ((64'(1) << L) - 1);
               r = ring & m; c = int'((ring >> W) & 1); end
      4: begin full = v << n; r = full & m; c = n ? int'((full >> W) & 1) : fin[0]; end
      5: begin r = v >> n; c = n ? int'((v >> (n-1)) & 1) : fin[0]; end
      6: begin r = 0; c = n ? 0 : fin[0]; end
      default: begin
        sv = ((v >> (W-1)) & 1) != 0 ? (v | ~m) : v;
        r = (sv >>> n) & m;
        c = n ? int'((sv >>> (n-1)) & 1) : fin[0];
      end
    endcase
    t1 = int'((r >> (W-1)) & 1);
    t0 = int'((r >> (W-2)) & 1);
    f = fin;
    f[0] = c[0];
    f[5] = (op == 0 || op == 2 || op == 4 || op == 6) ? c[0] ^ t1[0] : t1[0] ^ t0[0];
    if (op >= 4) begin
      f[2] = 1'b0;
      f[1] = ~^r[7:0];
      f[4] = t1[0];
      f[3] = (r == 0);
    end
    return {f, r[15:0]};
  endfunction

  task automatic issue(input int op, input bit wide, input int val, input int cnt,
                       input logic [5:0] fin);
    @(negedge clk);
    in_op = op[2:0]; in_wide = wide; in_operand = val[15:0];
    in_count = cnt[7:0]; in_flags = fin; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R12 out_valid after reset", out_valid, 0);
    check("R12 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_directed;
    issue(0, 0, 16'h0081, 1, 6'b000000);
    check("R5 rol8 result", out_result, 16'h0003);
    check("R8 rol8 flags", out_flags, 6'b100001);
    issue(0, 0, 16'hFF81, 1, 6'b000000);
    check("R1 narrow upper ignored", out_result, 16'h0003);
    issue(5, 1, 16'h8000, 1, 6'b000000);
    check("R9 shr16 result", out_result, 16'h4000);
    check("R9 shr16 flags", out_flags, 6'b100010);
    issue(7, 0, 16'h0080, 3, 6'b000000);
    check("R11 sar8 result", out_result, 16'h00F0);
    check("R7 sar8 flags", out_flags, 6'b010010);
    issue(6, 1, 16'h1234, 5, 6'b111111);
    check("R10 zero op result", out_result, 16'h0000);
    check("R10 zero op flags", out_flags, 6'b001010);
    issue(0, 0, 16'h0081, 32, 6'b000001);
    check("R3 masked zero result", out_result, 16'h0081);
    check("R3 masked zero flags", out_flags, 6'b000001);
    issue(3, 0, 16'h0001, 1, 6'b000001);
    check("R5 rcr8 result", out_result, 16'h0080);
    check("R4 rcr8 flags", out_flags, 6'b100001);
    issue(1, 1, 16'h0001, 33, 6'b011110);
    check("R2 count 33 result", out_result, 16'h8000);
    check("R6 ror16 flags kept", out_flags, 6'b111111);
  endtask

  task automatic t_sweep;
    int vals [4] = '{32'h8001, 32'h5A3C, 32'hFFFF, 32'h00C3};
    logic [21:0] e;
    string tag;
    for (int op = 0; op < 8; op++)
      for (int w = 0; w < 2; w++)
        for (int vi = 0; vi < 4; vi++)
          for (int cnt = 0; cnt < 64; cnt += 1) begin
            if (cnt >= 32 && cnt != 33 && cnt != 63) continue;
            e = model(op, w[0], vals[vi], cnt, 6'(vi * 13 + op));
            issue(op, w[0], vals[vi], cnt, 6'(vi * 13 + op));
            case (op)
              0, 1, 2, 3: tag = "R5 rotate";
              6: tag = "R10 zero op";
              7: tag = "R11 sar";
              default: tag = "R7 shift";
            endcase
            check($sformatf("%s op%0d w%0d cnt%0d result", tag, op, w, cnt), out_result, e[15:0]);
            check($sformatf("R4 R8 R9 op%0d w%0d cnt%0d flags", op, w, cnt), out_flags, e[21:16]);
          end
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 3'd4; in_wide = 1'b1; in_operand = 16'h0101; in_count = 8'd4;
    in_flags = 6'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_operand = 16'h0F0F;
    check("R12 stalled in_ready", in_ready, 0);
    check("R12 stalled out_valid", out_valid, 1);
    @(posedge clk);
    @(negedge clk);
    check("R12 stalled result held", out_result, 16'h1010);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 second result", out_result, 16'hF0F0);
    @(posedge clk);
    @(negedge clk);
    check("R12 drained", out_valid, 0);
  endtask

  initial begin
    #1;
    t_reset;
    #11 rst_n = 1'b1;
    t_directed;
    t_sweep;
    t_backpressure;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule